// File: doc/BRIEF.md
# Low-Latency Instruction Fetch Port

This block is the fetch front end of a 32-bit processor core. It keeps the instruction pointer and reads from simple on-chip instruction memory through a minimal port. The port has a combinational read enable, a word address, a data return path and a busy input from the slave. A read is issued in every cycle that the downstream pipeline can take an instruction. A read the slave reports busy on is retried. A jump redirects the pointer to a new target.

Addresses on the memory side count 32-bit words. The byte pointer drops its two low bits, and since instruction pointers are always word aligned, bit 0 of a jump target is reused as an interrupt-return flag. Data comes back in the cycle after an accepted read. The port then registers the instruction and presents it together with its word address. If the pipeline stalls while data is still in flight, that data is kept in a one-entry holding slot, so no fetched word is lost or delivered twice.

Top module: `ifetch_port`

## Requirements
- R1: While reset is low and in the first cycle after it, the valid output and the interrupt-return flag are 0 and the word address equals the start-address parameter with its two low bits removed.
- R2: The word address output is bits 31..2 of the byte pointer; a jump to byte address 0x10000000 presents 0x04000000 on the word address in the next cycle.
- R3: The read enable is combinational: it is 1 in the same cycle exactly when reset is high, the stall input is 0 and the jump input is 0.
- R4: A read is accepted when read enable is 1 and busy is 0; an accepted read advances the word address by one in the next cycle, while a read refused by busy leaves the address unchanged and is retried.
- R5: The data the slave returns in the cycle after an accepted read appears on the instruction output, with valid set and with the read's word address, in the cycle after that, provided no stall or jump intervenes.
- R6: With busy tied to 0, the port fetches consecutive words and delivers one instruction per cycle, even if the slave drives data in cycles without a read enable.
- R7: On a jump, the interrupt-return flag output takes bit 0 of the target from the next cycle and keeps it until the next jump; bit 1 of the target is ignored.
- R8: A jump discards every instruction fetched before it: valid is 0 in the cycle after the jump, and only words from the new target onward are delivered.
- R9: While the stall input is 1 the instruction, its address and valid hold their values, and data arriving during the stall is delivered after the stall in fetch order, with no word lost or duplicated.
- R10: A jump takes effect even in a cycle where the stall input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Downstream cannot accept an instruction this cycle |
| jump_i | input | 1 | Redirect the fetch pointer to jump_tgt_i |
| jump_tgt_i | input | 32 | Byte target of the jump; bit 0 is the interrupt-return flag |
| rd_en_o | output | 1 | Combinational read enable to the memory |
| word_adr_o | output | 30 | Word address of the read |
| rd_data_i | input | 32 | Read data, valid the cycle after an accepted read |
| busy_i | input | 1 | Slave cannot take the read this cycle |
| instr_valid_o | output | 1 | instr_o and instr_adr_o hold a fetched instruction |
| instr_o | output | 32 | Fetched instruction word |
| instr_adr_o | output | 30 | Word address of instr_o |
| irf_o | output | 1 | Interrupt-return flag from the last jump target |

## Verification
The bench drives stall and busy patterns that overlap, so a read is often in flight at the moment a stall rises. A design without the holding slot would drop that word, and one that fetched while stalled would deliver a word twice. Jumps are placed in stall cycles, in busy cycles and back to back, where a design that failed to flush would deliver a stale word after the redirect. One slave mode returns data on every cycle without regard to read enable, which exposes a port that captures data it never asked for. Targets with bits 0 and 1 set confirm that the flag is split off and the address is truncated, and a start address with its low bits set checks the reset pointer.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    // Source that feeds the instruction output register in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_BUS  = 2'd2
    } src_e;

endpackage

// File: rtl/ifetch_ptr.sv
module ifetch_ptr #(
    parameter int unsigned           ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]     START_ADDR = '0,
    localparam int unsigned          WADR_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jump_i,
    input  logic [ADDR_W-1:0] jump_tgt_i,
    input  logic              adv_i,
    output logic [WADR_W-1:0] pc_o,
    output logic              irf_o
);

    localparam logic [WADR_W-1:0] RST_PC = START_ADDR[ADDR_W-1:2];

    typedef struct packed {
        logic [WADR_W-1:0] pc;
        logic              irf;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    // Bit 1 of a target has no meaning for word-aligned code.
    logic tgt_b1_unused;
    assign tgt_b1_unused = jump_tgt_i[1];

    always_comb begin
        st_d = st_q;
        if (jump_i) begin
            st_d.pc  = jump_tgt_i[ADDR_W-1:2];
            st_d.irf = jump_tgt_i[0];
        end else if (adv_i) begin
            st_d.pc = st_q.pc + WADR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc  <= RST_PC;
            st_q.irf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o  = st_q.pc;
    assign irf_o = st_q.irf;

endmodule

// File: rtl/ifetch_track.sv
module ifetch_track
    import ifetch_pkg::*;
#(
    parameter int unsigned WADR_W = 30,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              jump_i,
    input  logic              accept_i,
    input  logic [WADR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output src_e              src_o,
    output logic [WADR_W-1:0] pend_adr_o,
    output logic [WADR_W-1:0] hold_adr_o,
    output logic [DATA_W-1:0] hold_dat_o
);

    typedef struct packed {
        logic              pend_v;
        logic [WADR_W-1:0] pend_adr;
        logic              hold_v;
        logic [WADR_W-1:0] hold_adr;
        logic [DATA_W-1:0] hold_dat;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (jump_i) begin
            st_d.pend_v = 1'b0;
            st_d.hold_v = 1'b0;
        end else begin
            // Data landing while stalled is parked so it is not lost.
            if (stall_i && st_q.pend_v) begin
                st_d.hold_v   = 1'b1;
                st_d.hold_adr = st_q.pend_adr;
                st_d.hold_dat = rd_data_i;
            end else if (!stall_i) begin
                st_d.hold_v = 1'b0;
            end
            st_d.pend_v = accept_i;
            if (accept_i) begin
                st_d.pend_adr = pc_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.hold_v) begin
            src_o = SRC_HOLD;
        end else if (st_q.pend_v) begin
            src_o = SRC_BUS;
        end else begin
            src_o = SRC_NONE;
        end
    end

    assign pend_adr_o = st_q.pend_adr;
    assign hold_adr_o = st_q.hold_adr;
    assign hold_dat_o = st_q.hold_dat;

endmodule

// File: rtl/ifetch_outreg.sv
module ifetch_outreg
    import ifetch_pkg::*;
#(
    parameter int unsigned WADR_W = 30,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              jump_i,
    input  src_e              src_i,
    input  logic [WADR_W-1:0] pend_adr_i,
    input  logic [DATA_W-1:0] bus_dat_i,
    input  logic [WADR_W-1:0] hold_adr_i,
    input  logic [DATA_W-1:0] hold_dat_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] instr_o,
    output logic [WADR_W-1:0] adr_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] instr;
        logic [WADR_W-1:0] adr;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (jump_i) begin
            st_d.valid = 1'b0;
        end else if (!stall_i) begin
            unique case (src_i)
                SRC_HOLD: begin
                    st_d.valid = 1'b1;
                    st_d.instr = hold_dat_i;
                    st_d.adr   = hold_adr_i;
                end
                SRC_BUS: begin
                    st_d.valid = 1'b1;
                    st_d.instr = bus_dat_i;
                    st_d.adr   = pend_adr_i;
                end
                default: begin
                    st_d.valid = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign instr_o = st_q.instr;
    assign adr_o   = st_q.adr;

endmodule

// File: rtl/ifetch_port.sv
module ifetch_port
    import ifetch_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] START_ADDR = '0,
    localparam int unsigned      WADR_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              jump_i,
    input  logic [ADDR_W-1:0] jump_tgt_i,
    output logic              rd_en_o,
    output logic [WADR_W-1:0] word_adr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              busy_i,
    output logic              instr_valid_o,
    output logic [DATA_W-1:0] instr_o,
    output logic [WADR_W-1:0] instr_adr_o,
    output logic              irf_o
);

    logic              accept;
    logic [WADR_W-1:0] pc;
    src_e              src;
    logic [WADR_W-1:0] pend_adr;
    logic [WADR_W-1:0] hold_adr;
    logic [DATA_W-1:0] hold_dat;

    // Unregistered enable so a single-cycle memory sees the request now.
    assign rd_en_o    = rst_n & ~stall_i & ~jump_i;
    assign accept     = rd_en_o & ~busy_i;
    assign word_adr_o = pc;

    ifetch_ptr #(
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .jump_i     (jump_i),
        .jump_tgt_i (jump_tgt_i),
        .adv_i      (accept),
        .pc_o       (pc),
        .irf_o      (irf_o)
    );

    ifetch_track #(
        .WADR_W (WADR_W),
        .DATA_W (DATA_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_i    (stall_i),
        .jump_i     (jump_i),
        .accept_i   (accept),
        .pc_i       (pc),
        .rd_data_i  (rd_data_i),
        .src_o      (src),
        .pend_adr_o (pend_adr),
        .hold_adr_o (hold_adr),
        .hold_dat_o (hold_dat)
    );

    ifetch_outreg #(
        .WADR_W (WADR_W),
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_i    (stall_i),
        .jump_i     (jump_i),
        .src_i      (src),
        .pend_adr_i (pend_adr),
        .bus_dat_i  (rd_data_i),
        .hold_adr_i (hold_adr),
        .hold_dat_i (hold_dat),
        .valid_o    (instr_valid_o),
        .instr_o    (instr_o),
        .adr_o      (instr_adr_o)
    );

endmodule

// File: rtl/ifetch_port_chk.sv
module ifetch_port_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WADR_W = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall_i,
    input logic              jump_i,
    input logic [ADDR_W-1:0] jump_tgt_i,
    input logic              rd_en_o,
    input logic [WADR_W-1:0] word_adr_o,
    input logic              busy_i,
    input logic              instr_valid_o,
    input logic [DATA_W-1:0] instr_o,
    input logic [WADR_W-1:0] instr_adr_o,
    input logic              irf_o
);

    // R2
    jump_word_adr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> word_adr_o == $past(jump_tgt_i[ADDR_W-1:2]));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && !busy_i) |=> word_adr_o == $past(word_adr_o) + WADR_W'(1));

    // R4
    busy_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && busy_i) |=> $stable(word_adr_o));

    // R7
    irf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> irf_o == $past(jump_tgt_i[0]));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> !instr_valid_o);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !jump_i) |=>
            $stable(instr_valid_o) && $stable(instr_o) && $stable(instr_adr_o));

endmodule

bind ifetch_port ifetch_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .jump_i        (jump_i),
    .jump_tgt_i    (jump_tgt_i),
    .rd_en_o       (rd_en_o),
    .word_adr_o    (word_adr_o),
    .busy_i        (busy_i),
    .instr_valid_o (instr_valid_o),
    .instr_o       (instr_o),
    .instr_adr_o   (instr_adr_o),
    .irf_o         (irf_o)
);

// File: tb/tb_ifetch_port.sv
`timescale 1ns/1ps
module tb_ifetch_port;

    localparam logic [31:0] START = 32'h0000_1003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic        jump_i = 1'b0;
    logic [31:0] jump_tgt_i = '0;
    logic        rd_en_o;
    logic [29:0] word_adr_o;
    logic [31:0] rd_data_i;
    logic        busy_i = 1'b0;
    logic        instr_valid_o;
    logic [31:0] instr_o;
    logic [29:0] instr_adr_o;
    logic        irf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit ign_en = 1'b0;
    int unsigned seed = 32'h2545_F491;

    always #2 clk = ~clk;

    ifetch_port #(.START_ADDR(START)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall_i),
        .jump_i        (jump_i),
        .jump_tgt_i    (jump_tgt_i),
        .rd_en_o       (rd_en_o),
        .word_adr_o    (word_adr_o),
        .rd_data_i     (rd_data_i),
        .busy_i        (busy_i),
        .instr_valid_o (instr_valid_o),
        .instr_o       (instr_o),
        .instr_adr_o   (instr_adr_o),
        .irf_o         (irf_o)
    );

    function automatic logic [31:0] memf(input logic [29:0] a);
        return {~a[15:0], a[15:0]} ^ {2'b00, a} ^ 32'h1357_0000;
    endfunction

    // Memory slave: answers one cycle after a read it was able to take.
    always_ff @(posedge clk) begin
        if (ign_en || (rd_en_o && !busy_i)) rd_data_i <= memf(word_adr_o);
        else                                rd_data_i <= 32'hDEAD_BEEF;
    end

    // Reference model state
    logic [29:0] m_pc;
    logic        m_irf;
    logic        m_ov;
    logic [29:0] m_oadr;
    logic [29:0] m_flight[$];
    logic [29:0] m_hold[$];

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string req);
        logic exp_en;
        exp_en = rst_n && !stall_i && !jump_i;
        chk(rd_en_o === exp_en, req, "rd_en_o", 32'(rd_en_o), 32'(exp_en));
        chk(word_adr_o === m_pc, req, "word_adr_o", 32'(word_adr_o), 32'(m_pc));
        chk(instr_valid_o === m_ov, req, "instr_valid_o", 32'(instr_valid_o), 32'(m_ov));
        chk(irf_o === m_irf, req, "irf_o", 32'(irf_o), 32'(m_irf));
        if (m_ov) begin
            chk(instr_adr_o === m_oadr, req, "instr_adr_o", 32'(instr_adr_o), 32'(m_oadr));
            chk(instr_o === memf(m_oadr), req, "instr_o", instr_o, memf(m_oadr));
        end
    endtask

    task automatic model_update();
        bit acc;
        if (!rst_n) begin
            m_pc  = START[31:2];
            m_irf = 1'b0;
            m_ov  = 1'b0;
            m_flight.delete();
            m_hold.delete();
        end else if (jump_i) begin
            m_pc  = jump_tgt_i[31:2];
            m_irf = jump_tgt_i[0];
            m_ov  = 1'b0;
            m_flight.delete();
            m_hold.delete();
        end else begin
            acc = !stall_i && !busy_i;
            if (!stall_i) begin
                if (m_hold.size() > 0) begin
                    m_ov = 1'b1;
                    m_oadr = m_hold.pop_front();
                end else if (m_flight.size() > 0) begin
                    m_ov = 1'b1;
                    m_oadr = m_flight.pop_front();
                end else begin
                    m_ov = 1'b0;
                end
            end else if (m_flight.size() > 0) begin
                m_hold.push_back(m_flight.pop_front());
            end
            m_flight.delete();
            if (acc) begin
                m_flight.push_back(m_pc);
                m_pc = m_pc + 30'd1;
            end
        end
    endtask

    task automatic step(input logic rv, input logic st, input logic bz,
                        input logic jp, input logic [31:0] tg, input string req);
        @(negedge clk);
        rst_n = rv; stall_i = st; busy_i = bz; jump_i = jp; jump_tgt_i = tg;
        #1;
        compare(req);
        @(posedge clk);
        model_update();
    endtask

    initial begin
        m_pc = START[31:2]; m_irf = 1'b0; m_ov = 1'b0; m_oadr = '0;
        // R1: reset state and start address with low bits ignored
        repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R1");
        // R6: never-busy slave that ignores the read enable
        ign_en = 1'b1;
        repeat (12) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R6");
        ign_en = 1'b0;
        // R5: plain streaming, data one cycle after the accepted read
        repeat (6) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R5");
        // R4: busy pattern with retries
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, (rnd() % 3) == 0, 1'b0, '0, "R4");
        // R9: stall rising while a word is in flight, then release
        step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R9");
        repeat (4) step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R9");
        repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R9");
        for (int i = 0; i < 40; i++)
            step(1'b1, (rnd() % 3) == 0, (rnd() % 4) == 0, 1'b0, '0, "R9");
        // R3: enable follows stall and jump in the same cycle
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, "R3");
        step(1'b1, 1'b0, 1'b1, 1'b0, '0, "R3");
        // R2: byte target 0x10000000 gives word 0x04000000
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h1000_0000, "R2");
        repeat (5) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R2");
        // R7: bit 0 is the flag, bit 1 ignored
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2003, "R7");
        repeat (4) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_3002, "R7");
        repeat (4) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");
        // R10: jump during stall with a parked word
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R10");
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_4001, "R10");
        repeat (4) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R10");
        // R8: jump while busy, back-to-back jumps
        step(1'b1, 1'b0, 1'b1, 1'b0, '0, "R8");
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_5000, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_6004, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_7008, "R8");
        repeat (5) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R8");
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic jp;
            jp = (rnd() % 16) == 0;
            step(1'b1, (rnd() % 4) == 0, (rnd() % 4) == 0, jp,
                 {rnd()[15:0], rnd()[15:0]}, jp ? "R8" : "R9");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule